// File: doc/BRIEF.md
# Banked Register Bit-Set Unit

This unit executes a single-bit set instruction against a byte-wide data register file. It takes one 16-bit instruction word together with the current bank register value and performs a read-modify-write of one register. The work is split over four phases: accept and decode, read, modify, write. The unit drives a synchronous register-file port whose read data appears one clock after the read strobe.

The 12-bit register address has a 4-bit bank number in its upper part and the 8-bit file field in its lower part. A flag in the instruction selects where the bank number comes from. With the flag clear, the address goes to a fixed access window: the lower half of the file range goes to bank 0 and the upper half to bank 15. With the flag set, the bank number comes from the bank register. An instruction is accepted only while the unit reports itself ready. The unit changes no status flags.

Top module: `bitset_unit`

## Requirements
- R1: An instruction is accepted on a clock edge where `ready` is high, `instr_valid` is high and `instr[15:12]` equals 4'b1000. A word with any other top nibble is ignored: it causes no read strobe, no write and no change in `ready`.
- R2: Bits `instr[11:9]` give the bit index (0 to 7), bit `instr[8]` is the bank-source flag, and bits `instr[7:0]` are the file field. Every bit index 0 to 7 sets the matching data bit.
- R3: With the flag at 0, the address is {4'h0, f} for f below 0x80 and {4'hF, f} for f of 0x80 and above. The `bsr` input has no effect on the address in this case.
- R4: With the flag at 1, the address is {bsr, f}, with `bsr` sampled on the accepting edge.
- R5: The written byte is the read byte with the selected bit forced to 1 and every other bit unchanged. For example, setting bit 7 of a register holding 0x0A writes 0x8A.
- R6: `rf_re` is high in the cycle after acceptance, and `rf_we` is high two cycles after that, with the same `rf_addr`. `ready` is low for exactly these three cycles and is high again after the write cycle.
- R7: Setting a bit that is already 1 still produces a write cycle, and that write stores the unchanged value.
- R8: A synchronous active-high `rst` returns the unit to the ready phase with `rf_re` and `rf_we` low. An operation in progress is abandoned without a write.
- R9: Instructions presented while `ready` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is present |
| instr | input | 16 | Instruction word |
| bsr | input | 4 | Bank register value |
| ready | output | 1 | Unit is in the accept phase |
| rf_addr | output | 12 | Register-file address |
| rf_re | output | 1 | Read strobe; data is returned on the next cycle |
| rf_rdata | input | 8 | Read data from the register file |
| rf_we | output | 1 | Write enable |
| rf_wdata | output | 8 | Write data |

## Verification
Take the edge that accepts an instruction as edge k. The read strobe is due in the cycle after edge k. The write enable, address and data are due in the cycle after edge k+2, and the memory is updated at edge k+3. The bench's reference model steps through the same phase count from its own decode. The bench compares `ready`, `rf_re`, `rf_we`, and during the write cycle the address and data, at every falling edge, so each result is checked in the exact cycle it is due. Ignored or abandoned instructions are confirmed by the absence of strobes in those cycles and by reading the register-file image afterwards.

// File: rtl/bitset_unit.sv
module bitset_unit #(
  parameter int DW = 8,
  parameter int FW = 8,
  parameter int BW = 4,
  parameter logic [3:0] OPC = 4'b1000,
  localparam int AW = BW + FW,
  localparam int IXW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          instr_valid,
  input  logic [15:0]   instr,
  input  logic [BW-1:0] bsr,
  output logic          ready,
  output logic [AW-1:0] rf_addr,
  output logic          rf_re,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [DW-1:0] rf_wdata
);

  typedef enum logic [1:0] {PH_DEC, PH_RD, PH_MOD, PH_WR} ph_t;

  ph_t            ph;
  logic [IXW-1:0] bit_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  mod_q;
  logic [FW-1:0]  f_in;
  logic [BW-1:0]  bank;
  logic           accept;

  assign f_in   = instr[FW-1:0];
  assign bank   = instr[8] ? bsr : (f_in[FW-1] ? {BW{1'b1}} : {BW{1'b0}});
  assign accept = (ph == PH_DEC) && instr_valid && (instr[15:12] == OPC);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_DEC;
    end else begin
      case (ph)
        PH_DEC:  if (accept) ph <= PH_RD;
        PH_RD:   ph <= PH_MOD;
        PH_MOD:  ph <= PH_WR;
        default: ph <= PH_DEC;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      bit_q  <= instr[9 +: IXW];
      addr_q <= {bank, f_in};
    end
    if (ph == PH_MOD) mod_q <= rf_rdata | (DW'(1) << bit_q);
  end

  assign ready    = (ph == PH_DEC);
  assign rf_re    = (ph == PH_RD);
  assign rf_we    = (ph == PH_WR);
  assign rf_addr  = addr_q;
  assign rf_wdata = mod_q;

endmodule

// File: rtl/bitset_unit_chk.sv
module bitset_unit_chk #(
  parameter int DW = 8,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          ready,
  input logic [AW-1:0] rf_addr,
  input logic          rf_re,
  input logic [DW-1:0] rf_rdata,
  input logic          rf_we,
  input logic [DW-1:0] rf_wdata
);

  a_r6_read_then_write: assert property (@(posedge clk) disable iff (rst)
    rf_re |-> ##2 rf_we);

  a_r6_ready_after_write: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> ready);

  a_r6_addr_held: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_addr == $past(rf_addr, 2)));

  a_r5_single_bit_set: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> ((($past(rf_rdata) & ~rf_wdata) == '0) &&
               ($countones(rf_wdata ^ $past(rf_rdata)) <= 1)));

  a_r9_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (!ready && !rf_we) |=> !ready);

  a_r8_reset_state: assert property (@(posedge clk)
    rst |=> (ready && !rf_re && !rf_we));

endmodule

bind bitset_unit bitset_unit_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .rf_addr(rf_addr), .rf_re(rf_re),
  .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata)
);

// File: tb/bitset_unit_bench.sv
module bitset_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [3:0]  bsr = '0;
  logic        ready, rf_re, rf_we;
  logic [11:0] rf_addr;
  logic [7:0]  rf_rdata, rf_wdata;

  logic [7:0] mem  [4096];
  logic [7:0] refm [4096];

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int mph = 0;
  logic [11:0] pa;
  logic [7:0]  pd;
  string cur_tag = "R6";

  always #4 clk = ~clk;

  bitset_unit u_bitset_unit (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr), .bsr(bsr),
    .ready(ready), .rf_addr(rf_addr), .rf_re(rf_re), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_wdata(rf_wdata)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 37) ^ (i >> 4));
  endfunction

  function automatic logic [15:0] mk(int b, int a, int f);
    return {4'b1000, 3'(b), 1'(a), 8'(f)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rf_we) mem[rf_addr] <= rf_wdata;
    rf_rdata <= mem[rf_addr];
  end

  always @(posedge clk) begin
    cycles++;
    if (rst) mph = 0;
    else begin
      case (mph)
        0: if (instr_valid && instr[15:12] == 4'b1000) begin
             logic [3:0] bk;
             if (instr[8]) bk = bsr;
             else bk = (instr[7:0] >= 8'h80) ? 4'hF : 4'h0;
             pa = {bk, instr[7:0]};
             pd = refm[pa] | (8'd1 << instr[11:9]);
             mph = 1;
           end
        1: mph = 2;
        2: mph = 3;
        default: begin refm[pa] = pd; mph = 0; end
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R6 ready", 32'(ready), 32'(mph == 0));
      check("R6 rf_re", 32'(rf_re), 32'(mph == 1));
      check("R6 rf_we", 32'(rf_we), 32'(mph == 3));
      if (mph == 3) begin
        check(cur_tag, 32'(rf_addr), 32'(pa));
        check("R5 wdata", 32'(rf_wdata), 32'(pd));
      end
    end
  end

  task automatic issue(logic [15:0] w, logic [3:0] b);
    instr = w; bsr = b; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin mem[i] = init_val(i); refm[i] = init_val(i); end
    mem[12'h234] = 8'h0A; refm[12'h234] = 8'h0A;
    mem[12'h777] = 8'h00; refm[12'h777] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R8 reset ready", 32'(ready), 32'd1);
    check("R8 reset we", 32'(rf_we), 32'd0);

    cur_tag = "R5 addr";
    issue(mk(7, 1, 8'h34), 4'h2);
    check("R5 0x0A bit7", 32'(mem[12'h234]), 32'h8A);

    cur_tag = "R3 addr low";
    issue(mk(3, 0, 8'h10), 4'h5);
    check("R3 bsr ignored", 32'(mem[12'h510]), 32'(init_val(12'h510)));
    check("R3 low window", 32'(mem[12'h010]), 32'(refm[12'h010]));
    cur_tag = "R3 addr high";
    issue(mk(6, 0, 8'h90), 4'h5);
    check("R3 high window", 32'(mem[12'hF90]), 32'(refm[12'hF90]));

    cur_tag = "R4 addr";
    issue(mk(1, 1, 8'h90), 4'hC);
    check("R4 banked", 32'(mem[12'hC90]), 32'(refm[12'hC90]));

    cur_tag = "R2 addr";
    for (int b = 0; b < 8; b++) issue(mk(b, 1, 8'h77), 4'h7);
    check("R2 all bits", 32'(mem[12'h777]), 32'hFF);

    cur_tag = "R7 addr";
    issue(mk(4, 1, 8'h77), 4'h7);
    check("R7 unchanged", 32'(mem[12'h777]), 32'hFF);

    instr = 16'h9733; bsr = 4'h3; instr_valid = 1'b1;
    @(negedge clk);
    check("R1 other opcode", 32'(ready), 32'd1);
    instr_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 no write", 32'(mem[12'h333]), 32'(init_val(12'h333)));

    cur_tag = "R9 addr";
    instr = mk(0, 1, 8'h41); bsr = 4'h4; instr_valid = 1'b1;
    @(negedge clk);
    instr = mk(5, 1, 8'h42);
    repeat (3) @(negedge clk);
    instr_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 busy ignored", 32'(mem[12'h442]), 32'(init_val(12'h442)));
    check("R9 first done", 32'(mem[12'h441]), 32'(refm[12'h441]));

    instr = mk(2, 1, 8'h55); bsr = 4'h6; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R8 abort ready", 32'(ready), 32'd1);
    repeat (3) @(negedge clk);
    check("R8 abort no write", 32'(mem[12'h655]), 32'(init_val(12'h655)));

    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=finish", cycles);
    finish_run();
  end
endmodule